// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Selective Flag Update

This block is the arithmetic/logic stage of a small 16-bit coprocessor. Each cycle it takes a source value and a second operand, an operation code and the current carry. The second operand is either another register value or a 4-bit constant. It returns a 16-bit result and new zero, carry, sign and overflow values. The unit is purely combinational and holds no state.

Each operation affects only some of the flags. The unit therefore drives a separate write-enable for every flag and one for the result. The register stage behind it applies the update only where an enable is high. A flag value output has meaning only while its enable is high.

The unit covers:
- addition, with and without carry in;
- subtraction, with and without borrow, and compare;
- the bitwise operations: and, and-with-inverted-operand, or, exclusive-or and invert;
- increment and decrement;
- three right shifts: arithmetic, logical and halving;
- rotates through carry;
- byte swap, high-byte and low-byte extraction, and sign extension of the low byte.

Top module: `alu16_flags`

## Requirements
- R1: When `useImm` is 1, the second operand of every two-operand operation is `imm` zero-extended to 16 bits (a value from 0 to 15). When `useImm` is 0, the second operand is `srcB`.
- R2: Add (op 0) returns a+b. Add-with-carry (op 1) returns a+b+carryIn. Both enable all four flags. Carry is the carry out of bit 15. Overflow is 1 when both operands have the same bit 15 and the result's bit 15 differs from it.
- R3: Subtract (op 2) returns a-b. Subtract-with-carry (op 3) returns a-b-1 when carryIn is 0 and a-b when carryIn is 1. Both enable all four flags. Carry is 1 when no borrow occurs. Overflow is 1 when the operands differ in bit 15 and the result's bit 15 differs from a's bit 15.
- R4: Compare (op 4) produces the same flags as subtract, with all four enables high, but holds `resultWe` at 0.
- R5: The following operations enable only sign and zero; carry and overflow enables stay 0:
  - and (op 5) returns a&b;
  - bit-clear (op 6) returns a&~b;
  - exclusive-or (op 8) returns a^b.
- R6: Or (op 7) returns a|b and invert (op 9) returns ~a. For both, all four flag enables are 0.
- R7: Increment (op 10) returns a+1 and decrement (op 11) returns a-1, both wrapping modulo 2^16. Only the sign and zero enables are high.
- R8: Arithmetic shift right (op 12) returns a shifted right by one with bit 15 kept. Halving (op 13) does the same, except that an all-ones source gives 0. Both enable sign, carry and zero, and the new carry is bit 0 of a.
- R9: Logical shift right (op 14) returns a shifted right by one with a 0 entering bit 15. The sign flag is forced to 0. The sign, carry and zero enables are high, the overflow enable is low, and carry is bit 0 of a.
- R10: Rotate left (op 15) returns {a[14:0], carryIn} with carry = a[15]. Rotate right (op 16) returns {carryIn, a[15:1]} with carry = a[0]. Both enable sign, carry and zero.
- R11: Swap (op 17) returns {a[7:0], a[15:8]}. Sign-extend (op 20) copies a[7] into bits 15:8. For both, sign and zero come from the 16-bit result and only those two enables are high.
- R12: High-byte (op 18) returns a[15:8] in bits 7:0 with zeros above. Low-byte (op 19) returns a[7:0] with zeros above. For both, sign is bit 7 and zero tests bits 7:0; only those two enables are high.
- R13: `resultWe` is 1 for every operation except compare. Whenever the zero flag is enabled for a 16-bit result, it is 1 exactly when that result is 0.

Unlisted op codes behave as compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcA | input | 16 | Source register value |
| srcB | input | 16 | Second register value |
| imm | input | 4 | Immediate constant |
| useImm | input | 1 | Select immediate as second operand |
| op | input | 5 | Operation code |
| carryIn | input | 1 | Current carry flag |
| result | output | 16 | Operation result |
| resultWe | output | 1 | Result write enable |
| zeroOut | output | 1 | New zero flag |
| carryOut | output | 1 | New carry flag |
| signOut | output | 1 | New sign flag |
| ovOut | output | 1 | New overflow flag |
| zeroWe | output | 1 | Zero flag write enable |
| carryWe | output | 1 | Carry flag write enable |
| signWe | output | 1 | Sign flag write enable |
| ovWe | output | 1 | Overflow flag write enable |

## Verification
The unit has no state. A wrong control decode therefore shows at the ports in the same cycle as the operation code, either as a wrong flag enable or as a result taken from the wrong unit. The typical symptom is a carry or overflow enable raised by a logic or byte operation, or a result write raised by compare. A wrong carry-in mode in the adder shows as an off-by-one result, and only when carryIn is 0 for subtract-with-carry or 1 for add-with-carry. Stimulus therefore drives each operation with both carry values. It also drives the operand pairs that sit on the carry, overflow and all-ones boundaries.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_BIC  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_NOT  = 5'd9,  OP_INC  = 5'd10, OP_DEC  = 5'd11,
    OP_ASR  = 5'd12, OP_DIV2 = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
    OP_ROR  = 5'd16, OP_SWAP = 5'd17, OP_HIB  = 5'd18, OP_LOB  = 5'd19,
    OP_SEX  = 5'd20
  } alu_op_e;

  typedef enum logic [1:0] {U_ADD, U_LOGIC, U_SHIFT, U_BYTE} unit_e;
  typedef enum logic [2:0] {LG_AND, LG_BIC, LG_OR, LG_XOR, LG_NOT} logic_e;
  typedef enum logic [2:0] {SH_ASR, SH_DIV2, SH_LSR, SH_ROL, SH_ROR} shift_e;
  typedef enum logic [1:0] {BY_SWAP, BY_HIB, BY_LOB, BY_SEX} byte_e;
  typedef enum logic [1:0] {AB_OPER, AB_ZERO, AB_ONES} addB_e;
  typedef enum logic [1:0] {AC_ZERO, AC_ONE, AC_CARRY} addC_e;

  typedef struct packed {
    unit_e  unit;
    logic_e logicSel;
    shift_e shiftSel;
    byte_e  byteSel;
    addB_e  addB;
    addC_e  addC;
    logic   invB;
    logic   halfFlags;
    logic   forceSignLow;
    logic   weRes;
    logic   weZ;
    logic   weC;
    logic   weS;
    logic   weV;
  } alu_ctrl_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [4:0] op,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl              = '0;
    ctrl.unit         = U_ADD;
    ctrl.logicSel     = LG_AND;
    ctrl.shiftSel     = SH_ASR;
    ctrl.byteSel      = BY_SWAP;
    ctrl.addB         = AB_OPER;
    ctrl.addC         = AC_ZERO;
    ctrl.weRes        = 1'b1;
    unique case (op)
      OP_ADD: begin
        ctrl.addC = AC_ZERO;
        {ctrl.weZ, ctrl.weC, ctrl.weS, ctrl.weV} = 4'b1111;
      end
      OP_ADC: begin
        ctrl.addC = AC_CARRY;
        {ctrl.weZ, ctrl.weC, ctrl.weS, ctrl.weV} = 4'b1111;
      end
      OP_SUB: begin
        ctrl.invB = 1'b1;
        ctrl.addC = AC_ONE;
        {ctrl.weZ, ctrl.weC, ctrl.weS, ctrl.weV} = 4'b1111;
      end
      OP_SBC: begin
        ctrl.invB = 1'b1;
        ctrl.addC = AC_CARRY;
        {ctrl.weZ, ctrl.weC, ctrl.weS, ctrl.weV} = 4'b1111;
      end
      OP_AND, OP_BIC, OP_XOR: begin
        ctrl.unit     = U_LOGIC;
        ctrl.logicSel = (op == OP_AND) ? LG_AND :
                        (op == OP_BIC) ? LG_BIC : LG_XOR;
        {ctrl.weZ, ctrl.weS} = 2'b11;
      end
      OP_OR: begin
        ctrl.unit     = U_LOGIC;
        ctrl.logicSel = LG_OR;
      end
      OP_NOT: begin
        ctrl.unit     = U_LOGIC;
        ctrl.logicSel = LG_NOT;
      end
      OP_INC: begin
        ctrl.addB = AB_ZERO;
        ctrl.addC = AC_ONE;
        {ctrl.weZ, ctrl.weS} = 2'b11;
      end
      OP_DEC: begin
        ctrl.addB = AB_ONES;
        ctrl.addC = AC_ZERO;
        {ctrl.weZ, ctrl.weS} = 2'b11;
      end
      OP_ASR, OP_DIV2, OP_ROL, OP_ROR: begin
        ctrl.unit     = U_SHIFT;
        ctrl.shiftSel = (op == OP_ASR)  ? SH_ASR  :
                        (op == OP_DIV2) ? SH_DIV2 :
                        (op == OP_ROL)  ? SH_ROL  : SH_ROR;
        {ctrl.weZ, ctrl.weC, ctrl.weS} = 3'b111;
      end
      OP_LSR: begin
        ctrl.unit         = U_SHIFT;
        ctrl.shiftSel     = SH_LSR;
        ctrl.forceSignLow = 1'b1;
        {ctrl.weZ, ctrl.weC, ctrl.weS} = 3'b111;
      end
      OP_SWAP, OP_SEX: begin
        ctrl.unit    = U_BYTE;
        ctrl.byteSel = (op == OP_SWAP) ? BY_SWAP : BY_SEX;
        {ctrl.weZ, ctrl.weS} = 2'b11;
      end
      OP_HIB, OP_LOB: begin
        ctrl.unit      = U_BYTE;
        ctrl.byteSel   = (op == OP_HIB) ? BY_HIB : BY_LOB;
        ctrl.halfFlags = 1'b1;
        {ctrl.weZ, ctrl.weS} = 2'b11;
      end
      default: begin
        // compare and unused codes: subtract flags, no result write
        ctrl.invB  = 1'b1;
        ctrl.addC  = AC_ONE;
        ctrl.weRes = 1'b0;
        {ctrl.weZ, ctrl.weC, ctrl.weS, ctrl.weV} = 4'b1111;
      end
    endcase
  end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 4
) (
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [IMM_W-1:0] imm,
  input  logic             useImm,
  input  logic             carryIn,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroOut,
  output logic             carryOut,
  output logic             signOut,
  output logic             ovOut
);

  localparam int MSB  = WIDTH - 1;
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] operB;
  logic [WIDTH-1:0] addend;
  logic             addCin;
  logic [WIDTH:0]   sumWide;
  logic             addOv;
  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] shiftRes;
  logic             shiftCarry;
  logic [WIDTH-1:0] byteRes;
  logic [HALF-1:0]  lowHalf;
  logic [HALF-1:0]  highHalf;

  assign operB = useImm ? {{(WIDTH-IMM_W){1'b0}}, imm} : srcB;

  // adder operand and carry-in selection
  always_comb begin
    unique case (ctrl.addB)
      AB_ZERO: addend = '0;
      AB_ONES: addend = '1;
      default: addend = ctrl.invB ? ~operB : operB;
    endcase
    unique case (ctrl.addC)
      AC_ONE:   addCin = 1'b1;
      AC_CARRY: addCin = carryIn;
      default:  addCin = 1'b0;
    endcase
  end

  assign sumWide = {1'b0, srcA} + {1'b0, addend} + {{WIDTH{1'b0}}, addCin};
  assign addOv   = (srcA[MSB] == addend[MSB]) && (sumWide[MSB] != srcA[MSB]);

  // bitwise unit
  always_comb begin
    unique case (ctrl.logicSel)
      LG_BIC:  logicRes = srcA & ~operB;
      LG_OR:   logicRes = srcA | operB;
      LG_XOR:  logicRes = srcA ^ operB;
      LG_NOT:  logicRes = ~srcA;
      default: logicRes = srcA & operB;
    endcase
  end

  // single-step shifter
  always_comb begin
    shiftCarry = srcA[0];
    unique case (ctrl.shiftSel)
      SH_DIV2: shiftRes = (&srcA) ? '0 : {srcA[MSB], srcA[MSB:1]};
      SH_LSR:  shiftRes = {1'b0, srcA[MSB:1]};
      SH_ROL: begin
        shiftRes   = {srcA[MSB-1:0], carryIn};
        shiftCarry = srcA[MSB];
      end
      SH_ROR:  shiftRes = {carryIn, srcA[MSB:1]};
      default: shiftRes = {srcA[MSB], srcA[MSB:1]};
    endcase
  end

  // byte unit
  assign lowHalf  = srcA[HALF-1:0];
  assign highHalf = srcA[MSB:HALF];

  always_comb begin
    unique case (ctrl.byteSel)
      BY_HIB:  byteRes = {{HALF{1'b0}}, highHalf};
      BY_LOB:  byteRes = {{HALF{1'b0}}, lowHalf};
      BY_SEX:  byteRes = {{HALF{lowHalf[HALF-1]}}, lowHalf};
      default: byteRes = {lowHalf, highHalf};
    endcase
  end

  // result and carry mux
  always_comb begin
    carryOut = sumWide[WIDTH];
    unique case (ctrl.unit)
      U_LOGIC: result = logicRes;
      U_SHIFT: begin
        result   = shiftRes;
        carryOut = shiftCarry;
      end
      U_BYTE:  result = byteRes;
      default: result = sumWide[MSB:0];
    endcase
  end

  // flag derivation
  always_comb begin
    if (ctrl.halfFlags) begin
      zeroOut = (result[HALF-1:0] == '0);
      signOut = result[HALF-1];
    end else begin
      zeroOut = (result == '0);
      signOut = result[MSB];
    end
    if (ctrl.forceSignLow) signOut = 1'b0;
  end

  assign ovOut = addOv;

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 4
) (
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [IMM_W-1:0] imm,
  input  logic             useImm,
  input  logic [4:0]       op,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic             zeroOut,
  output logic             carryOut,
  output logic             signOut,
  output logic             ovOut,
  output logic             zeroWe,
  output logic             carryWe,
  output logic             signWe,
  output logic             ovWe
);

  alu_ctrl_t ctrl;

  alu16_ctrl i_ctrl (
    .op   (op),
    .ctrl (ctrl)
  );

  alu16_datapath #(.WIDTH(WIDTH), .IMM_W(IMM_W)) i_dp (
    .srcA     (srcA),
    .srcB     (srcB),
    .imm      (imm),
    .useImm   (useImm),
    .carryIn  (carryIn),
    .ctrl     (ctrl),
    .result   (result),
    .zeroOut  (zeroOut),
    .carryOut (carryOut),
    .signOut  (signOut),
    .ovOut    (ovOut)
  );

  assign resultWe = ctrl.weRes;
  assign zeroWe   = ctrl.weZ;
  assign carryWe  = ctrl.weC;
  assign signWe   = ctrl.weS;
  assign ovWe     = ctrl.weV;

endmodule

// File: rtl/alu16_checker.sv
module alu16_checker
  import alu16_pkg::*;
(
  input logic [15:0] srcA,
  input logic [4:0]  op,
  input logic [15:0] result,
  input logic        resultWe,
  input logic        zeroOut,
  input logic        carryOut,
  input logic        signOut,
  input logic        zeroWe,
  input logic        carryWe,
  input logic        signWe,
  input logic        ovWe
);

  logic szOnlyOp;
  assign szOnlyOp = (op == OP_AND) || (op == OP_BIC) || (op == OP_XOR) ||
                    (op == OP_INC) || (op == OP_DEC) || (op == OP_SWAP) ||
                    (op == OP_HIB) || (op == OP_LOB) || (op == OP_SEX);

  always_comb begin
    // R4
    cmp_no_write_chk: assert (!(op == OP_CMP) ||
                              (!resultWe && zeroWe && carryWe && signWe && ovWe))
      else $error("compare must update flags without result write");
    // R9
    lsr_sign_low_chk: assert (!(op == OP_LSR) || (signWe && !signOut && !ovWe))
      else $error("logical shift must force sign low");
    // R6
    or_not_flags_chk: assert (!((op == OP_OR) || (op == OP_NOT)) ||
                              (!zeroWe && !carryWe && !signWe && !ovWe))
      else $error("or/not must leave flags alone");
    // R5
    sz_only_chk: assert (!szOnlyOp || (zeroWe && signWe && !carryWe && !ovWe))
      else $error("sign/zero-only op touched carry or overflow");
    // R13
    zero_full_chk: assert (!(zeroWe && op != OP_HIB && op != OP_LOB) ||
                           (zeroOut == (result == 16'h0000)))
      else $error("zero flag disagrees with result");
    // R10
    rol_carry_chk: assert (!(op == OP_ROL) || (carryWe && carryOut == srcA[15]))
      else $error("rotate left carry must be the old top bit");
  end

endmodule

bind alu16_flags alu16_checker i_chk (
  .srcA     (srcA),
  .op       (op),
  .result   (result),
  .resultWe (resultWe),
  .zeroOut  (zeroOut),
  .carryOut (carryOut),
  .signOut  (signOut),
  .zeroWe   (zeroWe),
  .carryWe  (carryWe),
  .signWe   (signWe),
  .ovWe     (ovWe)
);

// File: tb/test_alu16_flags.sv
module test_alu16_flags;
  import alu16_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] srcA = '0, srcB = '0;
  logic [3:0]  imm = '0;
  logic        useImm = 1'b0;
  logic [4:0]  op = 5'd0;
  logic        carryIn = 1'b0;
  logic [15:0] result;
  logic        resultWe, zeroOut, carryOut, signOut, ovOut;
  logic        zeroWe, carryWe, signWe, ovWe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [24:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  alu16_flags i_alu16_flags (
    .srcA(srcA), .srcB(srcB), .imm(imm), .useImm(useImm), .op(op),
    .carryIn(carryIn), .result(result), .resultWe(resultWe),
    .zeroOut(zeroOut), .carryOut(carryOut), .signOut(signOut), .ovOut(ovOut),
    .zeroWe(zeroWe), .carryWe(carryWe), .signWe(signWe), .ovWe(ovWe)
  );

  // Reference model written from the requirements.
  function automatic logic [24:0] model(alu_op_e o, logic [15:0] a,
                                        logic [15:0] b, logic ci);
    logic [15:0] r;
    logic rw, zw, cw, sw, vw, z, c, s, v;
    logic [16:0] wide;
    r = 0; c = 0; v = 0;
    rw = 1; zw = 1; sw = 1; cw = 0; vw = 0;
    case (o)
      OP_ADD, OP_ADC: begin
        wide = 17'(a) + 17'(b) + ((o == OP_ADC) ? 17'(ci) : 17'd0);
        r = wide[15:0]; c = wide[16];
        v = (a[15] == b[15]) && (r[15] != a[15]); cw = 1; vw = 1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        logic borrowIn;
        borrowIn = (o == OP_SBC) ? !ci : 1'b0;
        r = a - b - 16'(borrowIn);
        c = (17'(a) >= 17'(b) + 17'(borrowIn));
        v = (a[15] != b[15]) && (r[15] != a[15]); cw = 1; vw = 1;
        if (o == OP_CMP) rw = 0;
      end
      OP_AND:  r = a & b;
      OP_BIC:  r = a & ~b;
      OP_XOR:  r = a ^ b;
      OP_OR:   begin r = a | b; zw = 0; sw = 0; end
      OP_NOT:  begin r = ~a;    zw = 0; sw = 0; end
      OP_INC:  r = a + 16'd1;
      OP_DEC:  r = a - 16'd1;
      OP_ASR:  begin r = 16'($signed(a) >>> 1); c = a[0]; cw = 1; end
      OP_DIV2: begin r = (a == 16'hFFFF) ? 16'h0 : 16'($signed(a) >>> 1); c = a[0]; cw = 1; end
      OP_LSR:  begin r = a >> 1; c = a[0]; cw = 1; end
      OP_ROL:  begin r = (a << 1) | 16'(ci); c = a[15]; cw = 1; end
      OP_ROR:  begin r = (a >> 1) | {ci, 15'd0}; c = a[0]; cw = 1; end
      OP_SWAP: r = {a[7:0], a[15:8]};
      OP_HIB:  r = a >> 8;
      OP_LOB:  r = a & 16'h00FF;
      OP_SEX:  r = a[7] ? (a | 16'hFF00) : (a & 16'h00FF);
      default: ;
    endcase
    if (o == OP_HIB || o == OP_LOB) begin s = r[7]; z = (r[7:0] == 0); end
    else begin s = (o == OP_LSR) ? 1'b0 : r[15]; z = (r == 0); end
    return {rw ? r : 16'h0, rw, zw, cw, sw, vw, z & zw, c & cw, s & sw, v & vw};
  endfunction

  task automatic drive(alu_op_e o, logic [15:0] a, logic [15:0] b,
                       logic [3:0] im, logic ui, logic ci, string tag);
    logic [15:0] bEff;
    @(posedge clk);
    #1;
    op = o; srcA = a; srcB = b; imm = im; useImm = ui; carryIn = ci;
    bEff = ui ? {12'h000, im} : b;
    expQ.push_back(model(o, a, bEff, ci));
    tagQ.push_back(tag);
  endtask

  // Monitor: compare at the falling edge, away from the driving edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [24:0] exp, act;
      string t;
      exp = expQ.pop_front();
      t = tagQ.pop_front();
      act = {resultWe ? result : 16'h0, resultWe, zeroWe, carryWe, signWe, ovWe,
             zeroOut & zeroWe, carryOut & carryWe, signOut & signWe, ovOut & ovWe};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s op=%0d actual=%h expected=%h", t, op, act, exp);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs give an add of zero (R13)
        drive(OP_ADD, 16'h0000, 16'h0000, 4'h0, 0, 0, "R13 reset");
        drive(OP_ADD, 16'h1234, 16'h1111, 4'h0, 0, 0, "R2");
        drive(OP_ADD, 16'h7FFF, 16'h0001, 4'h0, 0, 0, "R2 overflow");
        drive(OP_ADD, 16'hFFFF, 16'h0001, 4'h0, 0, 1, "R2 carry");
        drive(OP_ADC, 16'h00FF, 16'h0001, 4'h0, 0, 1, "R2 adc");
        drive(OP_ADC, 16'h8000, 16'h8000, 4'h0, 0, 0, "R2 adc ovf");
        drive(OP_ADD, 16'h0010, 16'hAAAA, 4'hF, 1, 0, "R1 imm");
        drive(OP_SUB, 16'h0005, 16'h0003, 4'h0, 0, 0, "R3");
        drive(OP_SUB, 16'h0003, 16'h0005, 4'h0, 0, 1, "R3 borrow");
        drive(OP_SUB, 16'h8000, 16'h0001, 4'h0, 0, 0, "R3 overflow");
        drive(OP_SBC, 16'h0005, 16'h0005, 4'h0, 0, 0, "R3 sbc c0");
        drive(OP_SBC, 16'h0005, 16'h0005, 4'h0, 0, 1, "R3 sbc c1");
        drive(OP_SUB, 16'h0009, 16'hFFFF, 4'h9, 1, 0, "R1 imm sub");
        drive(OP_CMP, 16'h0004, 16'h0004, 4'h0, 0, 0, "R4 equal");
        drive(OP_CMP, 16'h0001, 16'h7000, 4'h0, 0, 1, "R4 less");
        drive(OP_AND, 16'hF0F0, 16'h8F00, 4'h0, 0, 1, "R5 and");
        drive(OP_BIC, 16'hFFFF, 16'h00FF, 4'h0, 0, 0, "R5 bic");
        drive(OP_BIC, 16'h000C, 16'h0000, 4'hC, 1, 1, "R5 bic zero");
        drive(OP_XOR, 16'hAAAA, 16'h5555, 4'h0, 0, 0, "R5 xor");
        drive(OP_OR,  16'h0000, 16'h0000, 4'h3, 1, 1, "R6 or");
        drive(OP_NOT, 16'hFFFF, 16'h0000, 4'h0, 0, 0, "R6 not");
        drive(OP_INC, 16'hFFFF, 16'h0000, 4'h0, 0, 1, "R7 inc wrap");
        drive(OP_DEC, 16'h0000, 16'h0000, 4'h0, 0, 0, "R7 dec wrap");
        drive(OP_ASR, 16'h8001, 16'h0000, 4'h0, 0, 0, "R8 asr");
        drive(OP_ASR, 16'hFFFF, 16'h0000, 4'h0, 0, 0, "R8 asr ones");
        drive(OP_DIV2, 16'hFFFF, 16'h0000, 4'h0, 0, 0, "R8 div2 ones");
        drive(OP_DIV2, 16'hFFFE, 16'h0000, 4'h0, 0, 1, "R8 div2");
        drive(OP_LSR, 16'h8001, 16'h0000, 4'h0, 0, 0, "R9 lsr");
        drive(OP_LSR, 16'h0001, 16'h0000, 4'h0, 0, 1, "R9 lsr zero");
        drive(OP_ROL, 16'h8000, 16'h0000, 4'h0, 0, 1, "R10 rol");
        drive(OP_ROL, 16'h4000, 16'h0000, 4'h0, 0, 0, "R10 rol c0");
        drive(OP_ROR, 16'h0001, 16'h0000, 4'h0, 0, 0, "R10 ror");
        drive(OP_ROR, 16'h0002, 16'h0000, 4'h0, 0, 1, "R10 ror c1");
        drive(OP_SWAP, 16'h12F4, 16'h0000, 4'h0, 0, 0, "R11 swap");
        drive(OP_SEX, 16'h3380, 16'h0000, 4'h0, 0, 0, "R11 sex neg");
        drive(OP_SEX, 16'hFF00, 16'h0000, 4'h0, 0, 0, "R11 sex zero");
        drive(OP_HIB, 16'h80FF, 16'h0000, 4'h0, 0, 0, "R12 hib");
        drive(OP_HIB, 16'h00FF, 16'h0000, 4'h0, 0, 0, "R12 hib zero");
        drive(OP_LOB, 16'hFF00, 16'h0000, 4'h0, 0, 0, "R12 lob zero");
        drive(OP_LOB, 16'h0081, 16'h0000, 4'h0, 0, 0, "R12 lob neg");
        repeat (3) @(posedge clk);
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=hung expected=finished");
        end
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule